// File: doc/BRIEF.md
# Run-Length Loss-of-Signal Checker

This block sits behind a deserializer that delivers 10-bit parallel words. It decides whether the line has carried transitions recently enough for a clock recovery loop to trust it. Each valid word is classified as all zeros, all ones or mixed. The block counts how many uniform words of one polarity have arrived back to back. When that count reaches twelve, it raises a run-fail flag.

Run length is judged only at word granularity. A run of 120 to 128 identical bits may or may not trip the flag, depending on where it falls against the word boundaries. A run of 119 bits or fewer can never cover twelve whole words. A run of 129 bits or more always covers at least twelve whole words, whatever the alignment. The flag is combined with a frequency-valid input from an external frequency comparator into a permit-lock output, which a clock recovery controller uses to decide when it may lock onto the data.

Top module: `runlen_los_check`

## Requirements
- R1: `run_fail` rises at the clock edge that accepts the 12th consecutive valid word that is uniform with the same polarity as the words before it (all 10 bits 0, or all 10 bits 1). It is still low after the 11th such word.
- R2: A run of 119 or fewer identical bits in the serial stream (word bit 0 first) never raises `run_fail`, at any alignment.
- R3: A run of 129 or more identical bits always raises `run_fail`, at every one of the 10 possible alignments.
- R4: A uniform word whose polarity differs from the preceding uniform words restarts the count at 1. For example, 11 all-zero words followed by 11 all-one words leave `run_fail` low, and the 12th all-one word raises it.
- R5: `permit_lock` is high exactly when `freq_ok` is high and `run_fail` is low, within the same cycle.
- R6: A valid mixed word clears the count and drops `run_fail` at the edge that accepts it. A valid uniform word of either polarity leaves a raised `run_fail` high.
- R7: Cycles with `word_vld` low change neither the count nor `run_fail`, whatever is on `word`.
- R8: The count saturates at 12. `run_fail` stays high through arbitrarily long uniform runs and drops on the first mixed word.
- R9: While `rst_n` is low, and after it is released, `run_fail` is low and the count is zero. After reset, 11 uniform words do not raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_vld | input | 1 | High when `word` carries a received word |
| word | input | 10 | Parallel word from the deserializer |
| freq_ok | input | 1 | Frequency test result from the external comparator |
| run_fail | output | 1 | Run-length loss-of-signal flag |
| permit_lock | output | 1 | Frequency and run-length tests both pass |

## Verification
The hardest situations to reach are the alignment-dependent edges of the run window. A run of a given bit length must be placed at every phase against the word boundaries to show that 119 bits never trip the flag and 129 bits always do. The bench builds a serial bit stream for each run length and each of the ten offsets. The bits around the run alternate, so that the run is bounded exactly. The bench then packs the stream into words and predicts the outcome from the number of whole words the run covers. Saturation is reached with a run of two hundred uniform words, followed by a single mixed word.

// File: rtl/runlen_pkg.sv
package runlen_pkg;
  typedef enum logic [1:0] {
    POL_MIX  = 2'd0,
    POL_ZERO = 2'd1,
    POL_ONE  = 2'd2
  } pol_e;
endpackage

// File: rtl/runlen_rst_sync.sv
module runlen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/runlen_word_class.sv
module runlen_word_class
  import runlen_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic [WORD_W-1:0] word,
  output pol_e              cls
);
  logic all_one;
  logic all_zero;

  assign all_one  = &word;
  assign all_zero = ~|word;

  always_comb begin
    if (all_one)       cls = POL_ONE;
    else if (all_zero) cls = POL_ZERO;
    else               cls = POL_MIX;
  end

  always_comb begin
    assert ($onehot0({all_one, all_zero})); // R1 a word cannot be both polarities
  end
endmodule

// File: rtl/runlen_counter.sv
module runlen_counter
  import runlen_pkg::*;
#(
  parameter int RUN_WORDS = 12,
  localparam int CNT_W = $clog2(RUN_WORDS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  pol_e cls,
  output logic fail
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_WORDS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  pol_e             pol_q, pol_d;
  logic             fail_q, fail_d;

  always_comb begin
    cnt_d  = cnt_q;
    pol_d  = pol_q;
    fail_d = fail_q;
    if (vld) begin
      if (cls == POL_MIX) begin
        cnt_d  = '0;
        fail_d = 1'b0;
      end else if (cls == pol_q && cnt_q != '0) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = CNT_W'(1);
        pol_d = cls;
      end
      if (cnt_d == CNT_MAX) fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pol_q  <= POL_MIX;
      fail_q <= 1'b0;
    end else if (vld) begin
      cnt_q  <= cnt_d;
      pol_q  <= pol_d;
      fail_q <= fail_d;
    end
  end

  assign fail = fail_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R8
  AST_FAIL_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> cnt_q == CNT_MAX); // R1
  AST_MIX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && cls == POL_MIX) |=> (cnt_q == '0 && !fail_q)); // R6
  AST_UNIFORM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && fail_q && cls != POL_MIX) |=> fail_q); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> ($stable(cnt_q) && $stable(fail_q))); // R7
endmodule

// File: rtl/runlen_los_check.sv
module runlen_los_check
  import runlen_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int RUN_WORDS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              freq_ok,
  output logic              run_fail,
  output logic              permit_lock
);
  logic rst_n_int;
  pol_e cls;

  runlen_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  runlen_word_class #(.WORD_W(WORD_W)) u_cls (
    .word (word),
    .cls  (cls)
  );

  runlen_counter #(.RUN_WORDS(RUN_WORDS)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n_int),
    .vld  (word_vld),
    .cls  (cls),
    .fail (run_fail)
  );

  assign permit_lock = freq_ok & ~run_fail;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n_int |-> !run_fail); // R9
endmodule

// File: tb/sim_runlen_los_check.sv
module sim_runlen_los_check;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       word_vld;
  logic [9:0] word;
  logic       freq_ok;
  logic       run_fail;
  logic       permit_lock;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  runlen_los_check u0 (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
    .freq_ok(freq_ok), .run_fail(run_fail), .permit_lock(permit_lock)
  );

  localparam logic [9:0] MIXW = 10'b0101010101;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic send(input logic [9:0] w);
    word = w; word_vld = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [9:0] w);
    word = w; word_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendn(input int n, input logic [9:0] w);
    for (int i = 0; i < n; i++) send(w);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; word_vld = 1'b0; word = '0;
    repeat (3) @(negedge clk);
    chk("R9 flag low in reset", run_fail, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    freq_ok = 1'b1;
    do_reset();
    chk("R9 flag low after reset", run_fail, 1'b0);
    chk("R9 permit follows freq_ok", permit_lock, 1'b1);
    sendn(11, 10'h000);
    chk("R9 eleven words after reset", run_fail, 1'b0);
    send(MIXW);
  endtask

  task automatic t_threshold();
    send(MIXW);
    sendn(11, 10'h3FF);
    chk("R1 no flag after 11 words", run_fail, 1'b0);
    send(10'h3FF);
    chk("R1 flag after 12th word", run_fail, 1'b1);
    send(MIXW);
    chk("R6 mixed word clears flag", run_fail, 1'b0);
  endtask

  task automatic t_polarity();
    send(MIXW);
    sendn(11, 10'h000);
    sendn(11, 10'h3FF);
    chk("R4 11 zeros then 11 ones", run_fail, 1'b0);
    send(10'h3FF);
    chk("R4 12th one after flip", run_fail, 1'b1);
    send(10'h000);
    chk("R6 opposite uniform keeps flag", run_fail, 1'b1);
    send(MIXW);
    chk("R6 mixed clears after flip", run_fail, 1'b0);
    sendn(11, 10'h000);
    send(10'h001);
    sendn(11, 10'h000);
    chk("R6 mixed word restarts count", run_fail, 1'b0);
    send(MIXW);
  endtask

  task automatic t_idle();
    send(MIXW);
    sendn(11, 10'h000);
    idle(5, MIXW);
    chk("R7 invalid mixed ignored", run_fail, 1'b0);
    send(10'h000);
    chk("R7 count kept across gap", run_fail, 1'b1);
    idle(5, 10'h155);
    chk("R7 invalid word keeps flag", run_fail, 1'b1);
    send(MIXW);
  endtask

  task automatic t_saturate();
    send(MIXW);
    sendn(200, 10'h000);
    chk("R8 flag held over long run", run_fail, 1'b1);
    send(MIXW);
    chk("R8 first mixed clears", run_fail, 1'b0);
    sendn(11, 10'h000);
    chk("R8 count restarted, no wrap", run_fail, 1'b0);
    send(MIXW);
  endtask

  task automatic t_permit();
    send(MIXW);
    freq_ok = 1'b0; #1;
    chk("R5 freq low, run ok", permit_lock, 1'b0);
    freq_ok = 1'b1; #1;
    chk("R5 both pass", permit_lock, 1'b1);
    @(negedge clk);
    sendn(12, 10'h3FF);
    chk("R5 run fail blocks permit", permit_lock, 1'b0);
    freq_ok = 1'b0; #1;
    chk("R5 both fail", permit_lock, 1'b0);
    freq_ok = 1'b1;
    @(negedge clk);
    send(MIXW);
  endtask

  function automatic logic sbit(input int i, input int off, input int len, input logic p);
    if (i < off)            return ((off - 1 - i) % 2 == 0) ? ~p : p;
    else if (i < off + len) return p;
    else                    return ((i - off - len) % 2 == 0) ? ~p : p;
  endfunction

  task automatic run_stream(input logic p, input int off, input int len, input string req);
    int nw = (off + len) / 10 + 3;
    int full = 0;
    logic seen = 1'b0;
    logic exp;
    for (int k = 0; k < nw; k++)
      if (10 * k >= off && 10 * k + 9 < off + len) full++;
    exp = (full >= 12);
    send(MIXW);
    for (int k = 0; k < nw; k++) begin
      logic [9:0] w;
      for (int b = 0; b < 10; b++) w[b] = sbit(10 * k + b, off, len, p);
      send(w);
      seen |= run_fail;
    end
    send(MIXW);
    if (len <= 119 && exp) begin errors++; $display("FAIL R2 bench model"); end
    checks++;
    if (seen !== exp) begin
      errors++;
      $display("FAIL %s len=%0d off=%0d pol=%0b actual=%0b expected=%0b",
               req, len, off, p, seen, exp);
    end
  endtask

  task automatic t_streams();
    for (int off = 0; off < 10; off++) begin
      run_stream(1'b0, off, 119, "R2");
      run_stream(1'b1, off, 119, "R2");
      run_stream(1'b0, off, 129, "R3");
      run_stream(1'b1, off, 129, "R3");
      run_stream(1'b1, off, 124, "R3 band");
    end
  endtask

  initial begin
    rst_n = 1'b0; word_vld = 1'b0; word = '0; freq_ok = 1'b0;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_polarity();
    t_idle();
    t_saturate();
    t_permit();
    t_streams();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule